// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block watches sixteen maskable interrupt request lines and one non-maskable line, and tells the processor core when it has to leave its normal instruction stream. A rising edge on a request line sets a pending bit. Three separate permission checks stand between a pending maskable source and the core: a global enable flag, a per-source enable mask, and a priority-level threshold. The non-maskable line skips all three. Among the requests that pass, the block picks one winner and offers it as a cause code together with the address of its vector-table entry. The address is a programmable base plus the cause number times the entry size, and each entry holds the new program counter.

The offer uses a valid/ready pair. `entry_valid_o` is the valid signal and `ack_i` is the ready signal. The offer carries no payload that must stay fixed. While valid is high, a higher-ranked arrival may replace the offered cause before the core accepts it. Valid can fall without an acceptance when software changes the enable flag, the mask or the level. A transfer takes place only in a cycle where both signals are high. In that cycle the block:
- captures the winning cause in a readable cause register;
- clears that source's pending bit;
- raises the current level to the winner's level;
- saves the previous level in a one-deep shadow.

A return strobe copies the shadow back into the current level.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A 0-to-1 transition on `irq_i[i]` sets pending bit i on that clock edge. The bit stays set after the line falls and while the line stays high. A line held high sets the bit only once.
- R2: The global enable flag resets to 0. `gie_set_i` sets it and `gie_clr_i` clears it, and clear wins when both are high. While the flag is 0, no maskable source is offered, but its pending bit is kept.
- R3: A pending source i whose bit in the mask register (`mask_data_i[i]`, loaded by `mask_wr_i`) is 0 is not offered. Setting the mask bit later makes it eligible without a new edge.
- R4: Source i has priority level i+1. It is eligible only if i+1 is strictly greater than the current level `level_o`. Level 0 admits all sources, and level 16 admits no maskable source.
- R5: Among eligible maskable sources, the one with the highest index is offered.
- R6: A rising edge on `nmi_i` creates a non-maskable pending request with cause code 16. This request is offered regardless of the enable flag, the mask and the level, and it outranks every maskable source. A held-high line yields one entry.
- R7: When `ack_i` and `entry_valid_o` are both high on a clock edge, `cause_o` takes the offered cause. The offered source's pending bit clears, unless a new edge on that same line arrives in the same cycle.
- R8: `vector_o` equals `base_o`-register contents plus the cause times 4 (cause 0..15 for maskable sources, 16 for the non-maskable one). The base is loaded by `base_wr_i`.
- R9: On acceptance, `level_o` becomes the level of the accepted source (i+1, or 16 for the non-maskable source), and the previous level is saved. A pulse on `ret_i` restores the saved level. Acceptance takes precedence over `ret_i`, which takes precedence over `level_wr_i`.
- R10: `ack_i` while `entry_valid_o` is low has no effect on `cause_o`, `level_o` or any pending request.
- R11: After reset, `entry_valid_o`, `cause_o`, `level_o`, `gie_o` and the mask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Maskable request lines, edge-captured |
| nmi_i | input | 1 | Non-maskable request line, edge-captured |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Load per-source mask |
| mask_data_i | input | 16 | Mask value, bit i enables source i |
| base_wr_i | input | 1 | Load vector table base |
| base_data_i | input | 32 | Vector table base value |
| level_wr_i | input | 1 | Load current priority level |
| level_data_i | input | 5 | Level value (0..16) |
| ret_i | input | 1 | Return from handler: restore saved level |
| ack_i | input | 1 | Core ready to take the offered entry |
| entry_valid_o | output | 1 | An entry is offered |
| entry_cause_o | output | 5 | Cause code of the offered entry |
| vector_o | output | 32 | Vector-table entry address of the offered entry |
| cause_o | output | 5 | Cause register, captured on acceptance |
| level_o | output | 5 | Current priority level |
| gie_o | output | 1 | Global enable flag |

## Verification
A pending bit that is stuck or lost shows up at the ports one cycle after the triggering edge or the acceptance. It appears as an offer that never comes, or as an offer that comes back after it was taken. An incorrect level or shadow value becomes visible on `level_o` one cycle after acceptance or return. It also shows up as a source of just-eligible rank being blocked or let through. Ranking and permission faults are driven by setting up several sources at once and comparing the offered cause and vector, which change one cycle after the edge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  // Width needed to hold 0..n inclusive
  function automatic int unsigned code_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;

  assign rise   = req_i & ~req_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[i] && !req_q[i]) |=> pend_q[i]);
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !(req_i[i] && !req_q[i])) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irq_rank.sv
module irq_rank #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = 5,
  parameter int unsigned LW = 5
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic          gie_i,
  input  logic [LW-1:0] level_i,
  input  logic          nmi_pend_i,
  output logic          valid_o,
  output logic [CW-1:0] cause_o,
  output logic [LW-1:0] win_lvl_o,
  output logic [N-1:0]  sel_o,
  output logic          nmi_sel_o
);
  localparam logic [CW-1:0] NMI_CODE = CW'(N);
  localparam logic [LW-1:0] NMI_LVL  = LW'(N);

  logic [N-1:0] elig;

  for (genvar i = 0; i < N; i++) begin : g_elig
    localparam logic [LW-1:0] SRC_LVL = LW'(i + 1);
    assign elig[i] = pend_i[i] & mask_i[i] & gie_i & (SRC_LVL > level_i);
  end

  always_comb begin
    sel_o     = '0;
    nmi_sel_o = nmi_pend_i;
    cause_o   = '0;
    win_lvl_o = '0;
    valid_o   = 1'b0;
    if (nmi_pend_i) begin
      cause_o   = NMI_CODE;
      win_lvl_o = NMI_LVL;
      valid_o   = 1'b1;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (elig[i]) begin
          sel_o     = '0;
          sel_o[i]  = 1'b1;
          cause_o   = CW'(i);
          win_lvl_o = LW'(i + 1);
          valid_o   = 1'b1;
        end
      end
    end
  end

  // R5 / R6: at most one winner at a time
  always_comb begin
    a_one_winner_r5: assert ($onehot0({nmi_sel_o, sel_o}));
  end
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl #(
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic [LW-1:0] new_lvl_i,
  input  logic          ret_i,
  input  logic          wr_i,
  input  logic [LW-1:0] wr_data_i,
  output logic [LW-1:0] level_o
);
  logic [LW-1:0] level_q;
  logic [LW-1:0] shadow_q;

  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= '0;
      shadow_q <= '0;
    end else if (acc_i) begin
      shadow_q <= level_q;
      level_q  <= new_lvl_i;
    end else if (ret_i) begin
      level_q  <= shadow_q;
    end else if (wr_i) begin
      level_q  <= wr_data_i;
    end
  end

  p_raise_on_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> level_q == $past(new_lvl_i));
  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i ##1 (ret_i && !acc_i)) |=> level_q == $past(level_q, 2));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned ENTRY_SHIFT = 2,
  parameter int unsigned CW          = irq_entry_pkg::code_width(NUM_SRC),
  parameter int unsigned LW          = irq_entry_pkg::code_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_data_i,
  input  logic               base_wr_i,
  input  logic [ADDR_W-1:0]  base_data_i,
  input  logic               level_wr_i,
  input  logic [LW-1:0]      level_data_i,
  input  logic               ret_i,
  input  logic               ack_i,
  output logic               entry_valid_o,
  output logic [CW-1:0]      entry_cause_o,
  output logic [ADDR_W-1:0]  vector_o,
  output logic [CW-1:0]      cause_o,
  output logic [LW-1:0]      level_o,
  output logic               gie_o
);
  localparam logic [CW-1:0] NMI_CODE = CW'(NUM_SRC);

  logic               gie_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [ADDR_W-1:0]  base_q;
  logic [CW-1:0]      cause_q;
  logic [NUM_SRC-1:0] pend;
  logic [0:0]         nmi_pend;
  logic [NUM_SRC-1:0] sel;
  logic               nmi_sel;
  logic [LW-1:0]      win_lvl;
  logic               acc;
  logic [NUM_SRC-1:0] clr;
  logic [0:0]         nmi_clr;

  assign acc     = ack_i & entry_valid_o;
  assign clr     = acc ? sel : '0;
  assign nmi_clr = acc & nmi_sel;

  irq_pend_bank #(.N(NUM_SRC)) u_src_pend (
    .clk(clk), .rst_n(rst_n), .req_i(irq_i), .clr_i(clr), .pend_o(pend)
  );

  irq_pend_bank #(.N(1)) u_nmi_pend (
    .clk(clk), .rst_n(rst_n), .req_i(nmi_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  irq_rank #(.N(NUM_SRC), .CW(CW), .LW(LW)) u_rank (
    .pend_i(pend), .mask_i(mask_q), .gie_i(gie_q), .level_i(level_o),
    .nmi_pend_i(nmi_pend[0]), .valid_o(entry_valid_o), .cause_o(entry_cause_o),
    .win_lvl_o(win_lvl), .sel_o(sel), .nmi_sel_o(nmi_sel)
  );

  irq_level_ctl #(.LW(LW)) u_level (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .new_lvl_i(win_lvl), .ret_i(ret_i),
    .wr_i(level_wr_i), .wr_data_i(level_data_i), .level_o(level_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      mask_q  <= '0;
      base_q  <= '0;
      cause_q <= '0;
    end else begin
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
      if (mask_wr_i) mask_q <= mask_data_i;
      if (base_wr_i) base_q <= base_data_i;
      if (acc)       cause_q <= entry_cause_o;
    end
  end

  assign vector_o = base_q + (ADDR_W'(entry_cause_o) << ENTRY_SHIFT);
  assign cause_o  = cause_q;
  assign gie_o    = gie_q;

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && entry_cause_o != NMI_CODE) |-> gie_o);
  p_nmi_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend[0] |-> (entry_valid_o && entry_cause_o == NMI_CODE));
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !entry_valid_o) |=> cause_o == $past(cause_o));
endmodule

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        nmi = 1'b0;
  logic        gie_set = 1'b0, gie_clr = 1'b0;
  logic        mask_wr = 1'b0;
  logic [15:0] mask_data = '0;
  logic        base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic        level_wr = 1'b0;
  logic [4:0]  level_data = '0;
  logic        ret = 1'b0, ack = 1'b0;
  logic        valid;
  logic [4:0]  ecause, cause, level;
  logic [31:0] vec;
  logic        gie;

  int unsigned checks = 0;
  int unsigned errors = 0;
  localparam logic [31:0] BASE = 32'h0000_1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi),
    .gie_set_i(gie_set), .gie_clr_i(gie_clr), .mask_wr_i(mask_wr),
    .mask_data_i(mask_data), .base_wr_i(base_wr), .base_data_i(base_data),
    .level_wr_i(level_wr), .level_data_i(level_data), .ret_i(ret), .ack_i(ack),
    .entry_valid_o(valid), .entry_cause_o(ecause), .vector_o(vec),
    .cause_o(cause), .level_o(level), .gie_o(gie)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_irq(input logic [15:0] bits);
    irq = bits; step(); irq = '0; step();
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic set_level(input logic [4:0] l);
    level_wr = 1'b1; level_data = l; step(); level_wr = 1'b0;
  endtask

  task automatic set_mask(input logic [15:0] m);
    mask_wr = 1'b1; mask_data = m; step(); mask_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 valid", valid, 0);
    check("R11 cause", cause, 0);
    check("R11 level", level, 0);
    check("R11 gie", gie, 0);
    // mask reset: pending source with gie on must stay hidden
    gie_set = 1'b1; step(); gie_set = 1'b0;
    pulse_irq(16'h0001);
    check("R11 mask zero", valid, 0);
    set_mask(16'hFFFF);
    check("R3 late unmask", ecause, 0);
    do_ack(); do_ret();
  endtask

  task automatic t_basic();
    base_wr = 1'b1; base_data = BASE; step(); base_wr = 1'b0;
    pulse_irq(16'h0008);
    check("R1 pending after pulse", valid, 1);
    check("R7 offered cause", ecause, 3);
    check("R8 vector", vec, BASE + 32'd12);
    do_ack();
    check("R7 cause reg", cause, 3);
    check("R9 level raised", level, 4);
    check("R7 pending cleared", valid, 0);
    do_ret();
    check("R9 level restored", level, 0);
  endtask

  task automatic t_mask();
    set_mask(16'hFFDF);
    pulse_irq(16'h0020);
    check("R3 masked", valid, 0);
    set_mask(16'hFFFF);
    check("R3 unmasked keeps pending", ecause, 5);
    do_ack(); do_ret();
  endtask

  task automatic t_level();
    set_level(5'd8);
    pulse_irq(16'h0080);
    check("R4 equal level blocked", valid, 0);
    pulse_irq(16'h0100);
    check("R4 above level", ecause, 8);
    do_ack();
    check("R9 level 9", level, 9);
    do_ret();
    check("R9 restore 8", level, 8);
    check("R4 still blocked", valid, 0);
    set_level(5'd0);
    check("R4 after lowering", ecause, 7);
    do_ack(); do_ret();
  endtask

  task automatic t_rank();
    pulse_irq(16'h8404);
    check("R5 top index", ecause, 15);
    check("R8 vector 15", vec, BASE + 32'd60);
    do_ack();
    check("R4 level 16 blocks all", valid, 0);
    do_ret();
    check("R5 next", ecause, 10);
    do_ack(); do_ret();
    check("R5 last", ecause, 2);
    do_ack(); do_ret();
    check("R5 drained", valid, 0);
  endtask

  task automatic t_gie();
    gie_clr = 1'b1; step(); gie_clr = 1'b0;
    check("R2 cleared", gie, 0);
    pulse_irq(16'h0010);
    check("R2 gated", valid, 0);
    gie_set = 1'b1; gie_clr = 1'b1; step(); gie_set = 1'b0; gie_clr = 1'b0;
    check("R2 clear wins", gie, 0);
    check("R2 still gated", valid, 0);
    gie_set = 1'b1; step(); gie_set = 1'b0;
    check("R2 set releases", ecause, 4);
    do_ack(); do_ret();
  endtask

  task automatic t_idle_ack();
    logic [4:0] c0;
    c0 = cause;
    check("R10 idle", valid, 0);
    do_ack();
    check("R10 cause kept", cause, c0);
    check("R10 level kept", level, 0);
    check("R10 no offer", valid, 0);
  endtask

  task automatic t_nmi();
    gie_clr = 1'b1; step(); gie_clr = 1'b0;
    set_mask(16'h0000);
    set_level(5'd16);
    nmi = 1'b1; step();
    check("R6 bypass", valid, 1);
    check("R6 code", ecause, 16);
    check("R8 nmi vector", vec, BASE + 32'd64);
    do_ack();
    check("R6 cause reg", cause, 16);
    check("R6 held once", valid, 0);
    step();
    check("R6 held still once", valid, 0);
    nmi = 1'b0; step();
    do_ret();
    check("R9 nmi restore", level, 16);
    gie_set = 1'b1; step(); gie_set = 1'b0;
    set_mask(16'hFFFF);
    set_level(5'd0);
    irq = 16'h8000; nmi = 1'b1; step(); irq = '0; nmi = 1'b0; step();
    check("R6 outranks 15", ecause, 16);
    do_ack();
    check("R9 nmi level", level, 16);
    check("R6 blocks maskable", valid, 0);
    do_ret();
    check("R6 then 15", ecause, 15);
    do_ack(); do_ret();
  endtask

  task automatic t_held();
    irq = 16'h0002; step();
    check("R1 held offer", ecause, 1);
    do_ack(); do_ret();
    step();
    check("R1 held single", valid, 0);
    irq = '0; step();
    check("R1 drop no entry", valid, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_mask();
    t_level();
    t_rank();
    t_gie();
    t_idle_ack();
    t_nmi();
    t_held();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule